// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Ninth-Bit Address Filter

This block turns an asynchronous serial line into received characters. A one-cycle enable, `tick16`, pulses sixteen times per bit period. The receiver watches the idle-high line for a falling edge and confirms the start bit halfway through it. It then samples each data bit and the stop bit at their centres. Characters are eight or nine data bits long and arrive least significant bit first. In nine-bit mode the ninth bit follows data bit 7.

Finished characters go into a two-entry first-in first-out store. Each entry carries its own stop-bit error. The consumer sees the oldest character on the output pins and removes it with `popStrobe`. If a character finishes while both entries are occupied, it is dropped and a sticky overrun flag is raised. Further reception into the store stays blocked until `clearRx` is pulsed.

For multidrop links there is an address filter. In nine-bit mode it keeps only characters whose ninth bit is 1. A break, meaning an all-zero character whose stop bit is sampled low, produces a one-cycle wake pulse. After a low stop bit the receiver waits for the line to go high before it looks for the next start.

Top module: `addr_serial_rx`

## Requirements
- R1: After reset `dataAvail`, `rxData`, `rxNinth`, `frameErr`, `overrunErr` and `breakWake` are all 0.
- R2: In eight-bit mode (`cfgNineBit`=0) a frame is one low start bit, eight data bits LSB first, and one stop bit. The byte appears on `rxData` with `dataAvail`=1 and `rxNinth`=0.
- R3: In nine-bit mode (`cfgNineBit`=1) a ninth data bit follows data bit 7, and its value is shown on `rxNinth` next to the byte.
- R4: A low pulse on the line that ends before the middle of the start bit (the 8th oversample) starts no reception and stores nothing.
- R5: The store holds two characters and presents them oldest first. `popStrobe` removes the head. While `dataAvail`=1 and no pop is given, the presented character does not change, even when a new character is stored behind it.
- R6: A character whose stop bit is sampled low is stored with `frameErr`=1. The flag is shown only while that character is at the head.
- R7: A character that finishes while two characters are held is dropped and sets `overrunErr`. The flag stays set, and no character is stored, until `clearRx` is pulsed. `clearRx` clears the flag and leaves the held characters in place.
- R8: With `cfgAddrDet`=1 in nine-bit mode, characters whose ninth bit is 0 are discarded without being stored. In eight-bit mode `cfgAddrDet` has no effect.
- R9: A character with all data bits 0 and a low stop bit raises `breakWake` for exactly one cycle and is stored with `frameErr`=1. The receiver then waits for the line to return high before the next start bit is accepted.
- R10: The receiver advances only on cycles where `tick16`=1. With `tick16` held low a frame on the line is not received, and any `tick16` spacing is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversample enable, 16 per bit period |
| rxLine | input | 1 | Serial input line, idle high |
| cfgNineBit | input | 1 | 1 selects nine data bits |
| cfgAddrDet | input | 1 | 1 enables the ninth-bit address filter |
| popStrobe | input | 1 | Removes the head character |
| clearRx | input | 1 | Clears the overrun condition |
| rxData | output | 8 | Head character data, 0 when empty |
| rxNinth | output | 1 | Head character ninth bit |
| dataAvail | output | 1 | Store holds at least one character |
| frameErr | output | 1 | Head character had a low stop bit |
| overrunErr | output | 1 | Sticky overrun flag |
| breakWake | output | 1 | One-cycle pulse on a received break |

## Verification
Some properties are checked on every cycle. The overrun flag must stay set until a clear arrives. The head character and its flags must hold steady while it is present and not popped. The wake signal must be a single-cycle pulse. Newly presented characters must respect the address filter and the eight-bit ninth-bit rule. Other behaviour can only be shown by the bench's serial scenarios: bit order, glitch rejection, FIFO order, which character gets dropped on overrun, the recovery after a break, and reception at slower tick spacing.

// File: rtl/arx_pkg.sv
package arx_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic shiftIn;  // sample line into the shift register
    logic finish;   // sample stop bit and complete the character
  } rx_strobe_t;

  // One stored character.
  typedef struct packed {
    logic [7:0] data;
    logic       ninth;
    logic       ferr;
  } rx_entry_t;

endpackage

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineSync,
  input  logic       nineBit,
  output rx_strobe_t strobe
);

  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_HOLD
  } rx_state_t;

  rx_state_t state;
  logic [CW-1:0] sampCnt;
  logic [3:0]    bitIdx;
  logic [3:0]    lastIdx;
  logic          endOfBit;

  assign lastIdx  = nineBit ? 4'd8 : 4'd7;
  assign endOfBit = tick && (sampCnt == CW'(OSR - 1));

  always_comb begin
    strobe         = '0;
    strobe.shiftIn = (state == S_DATA) && endOfBit;
    strobe.finish  = (state == S_STOP) && endOfBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sampCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (tick && !lineSync) begin
            state   <= S_START;
            sampCnt <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (sampCnt == CW'(MID)) begin
              sampCnt <= '0;
              bitIdx  <= '0;
              state   <= lineSync ? S_IDLE : S_DATA;
            end else begin
              sampCnt <= sampCnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (endOfBit) begin
            sampCnt <= '0;
            if (bitIdx == lastIdx) state <= S_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end else if (tick) begin
            sampCnt <= sampCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (endOfBit) begin
            sampCnt <= '0;
            state   <= lineSync ? S_IDLE : S_HOLD;
          end else if (tick) begin
            sampCnt <= sampCnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (lineSync) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/arx_datapath.sv
module arx_datapath
  import arx_pkg::*;
#(
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       nineBit,
  input  logic       addrDet,
  input  logic       pop,
  input  logic       clear,
  input  rx_strobe_t strobe,
  output logic       lineSync,
  output logic [7:0] rxData,
  output logic       rxNinth,
  output logic       dataAvail,
  output logic       frameErr,
  output logic       overrunErr,
  output logic       breakWake
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [8:0]             shReg;
  rx_entry_t              mem [DEPTH];
  logic [PW-1:0]          rdPtr, wrPtr;
  logic [NW-1:0]          count;
  logic                   ovr;

  logic [7:0] chData;
  logic       chNinth, chFerr, chBreak, keep;
  logic       doPop, room, doPush, setOvr;
  rx_entry_t  head;

  // Line synchronizer, idle high.
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  // LSB-first shift register; eight-bit characters end one place high.
  always_ff @(posedge clk) begin
    if (!rstN)               shReg <= '0;
    else if (strobe.shiftIn) shReg <= {lineSync, shReg[8:1]};
  end

  assign chData  = nineBit ? shReg[7:0] : shReg[8:1];
  assign chNinth = nineBit & shReg[8];
  assign chFerr  = ~lineSync;
  assign chBreak = chFerr && (chData == 8'h00) && !chNinth;
  assign keep    = !(addrDet && nineBit && !chNinth);

  assign doPop  = pop && (count != '0);
  assign room   = (count < NW'(DEPTH)) || doPop;
  assign doPush = strobe.finish && keep && !ovr && room;
  assign setOvr = strobe.finish && keep && !ovr && !room;

  // Receive store.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= '{data: chData, ninth: chNinth, ferr: chFerr};
        wrPtr      <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovr       <= 1'b0;
      breakWake <= 1'b0;
    end else begin
      ovr       <= (ovr && !clear) || setOvr;
      breakWake <= strobe.finish && chBreak;
    end
  end

  assign head       = mem[rdPtr];
  assign dataAvail  = (count != '0);
  assign rxData     = dataAvail ? head.data : 8'h00;
  assign rxNinth    = dataAvail & head.ninth;
  assign frameErr   = dataAvail & head.ferr;
  assign overrunErr = ovr;

endmodule

// File: rtl/addr_serial_rx.sv
module addr_serial_rx
  import arx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic       cfgNineBit,
  input  logic       cfgAddrDet,
  input  logic       popStrobe,
  input  logic       clearRx,
  output logic [7:0] rxData,
  output logic       rxNinth,
  output logic       dataAvail,
  output logic       frameErr,
  output logic       overrunErr,
  output logic       breakWake
);

  rx_strobe_t strobe;
  logic       lineSync;

  arx_ctrl #(.OSR(OSR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick16),
    .lineSync (lineSync),
    .nineBit  (cfgNineBit),
    .strobe   (strobe)
  );

  arx_datapath #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .nineBit    (cfgNineBit),
    .addrDet    (cfgAddrDet),
    .pop        (popStrobe),
    .clear      (clearRx),
    .strobe     (strobe),
    .lineSync   (lineSync),
    .rxData     (rxData),
    .rxNinth    (rxNinth),
    .dataAvail  (dataAvail),
    .frameErr   (frameErr),
    .overrunErr (overrunErr),
    .breakWake  (breakWake)
  );

endmodule

// File: rtl/arx_checker.sv
module arx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgNineBit,
  input logic       cfgAddrDet,
  input logic       popStrobe,
  input logic       clearRx,
  input logic [7:0] rxData,
  input logic       rxNinth,
  input logic       dataAvail,
  input logic       frameErr,
  input logic       overrunErr,
  input logic       breakWake
);

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr && !clearRx |=> overrunErr);

  a_r7_ovr_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> dataAvail);

  a_r5_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    dataAvail && !popStrobe |=> dataAvail && $stable(rxData) && $stable(rxNinth) && $stable(frameErr));

  a_r9_wake_pulse: assert property (@(posedge clk) disable iff (!rstN)
    breakWake |=> !breakWake);

  a_r8_addr_filter: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataAvail) && $past(cfgAddrDet) && $past(cfgNineBit) |-> rxNinth);

  a_r2_eight_bit_ninth: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataAvail) && !$past(cfgNineBit) |-> !rxNinth);

endmodule

bind addr_serial_rx arx_checker u_arx_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cfgNineBit (cfgNineBit),
  .cfgAddrDet (cfgAddrDet),
  .popStrobe  (popStrobe),
  .clearRx    (clearRx),
  .rxData     (rxData),
  .rxNinth    (rxNinth),
  .dataAvail  (dataAvail),
  .frameErr   (frameErr),
  .overrunErr (overrunErr),
  .breakWake  (breakWake)
);

// File: tb/addr_serial_rx_bench.sv
`timescale 1ns/1ps
module addr_serial_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16;
  logic       rxLine = 1'b1;
  logic       cfgNineBit = 1'b0;
  logic       cfgAddrDet = 1'b0;
  logic       popStrobe = 1'b0;
  logic       clearRx = 1'b0;
  logic [7:0] rxData;
  logic       rxNinth, dataAvail, frameErr, overrunErr, breakWake;

  int checks = 0;
  int fails = 0;
  int wakeCnt = 0;
  int tickDiv = 1;
  logic tickOn = 1'b1;
  logic [3:0] tickCnt = '0;

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) tickCnt <= (int'(tickCnt) >= tickDiv - 1) ? 4'd0 : tickCnt + 4'd1;
  assign tick16 = tickOn && (tickCnt == 4'd0);

  always @(negedge clk) if (rstN && breakWake) wakeCnt++;

  addr_serial_rx u_addr_serial_rx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .cfgNineBit(cfgNineBit), .cfgAddrDet(cfgAddrDet),
    .popStrobe(popStrobe), .clearRx(clearRx),
    .rxData(rxData), .rxNinth(rxNinth), .dataAvail(dataAvail),
    .frameErr(frameErr), .overrunErr(overrunErr), .breakWake(breakWake)
  );

  typedef struct packed {
    logic       nine;
    logic       addr;
    logic [8:0] val;
    logic       stopHi;
    logic       keep;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1},  // R2
    '{1'b0, 1'b0, 9'h0FF, 1'b1, 1'b1},  // R2
    '{1'b1, 1'b0, 9'h155, 1'b1, 1'b1},  // R3 ninth 1
    '{1'b1, 1'b0, 9'h02A, 1'b1, 1'b1},  // R3 ninth 0
    '{1'b1, 1'b1, 9'h0C3, 1'b1, 1'b0},  // R8 discarded
    '{1'b1, 1'b1, 9'h181, 1'b1, 1'b1},  // R8 address kept
    '{1'b0, 1'b1, 9'h055, 1'b1, 1'b1},  // R8 filter off in 8-bit
    '{1'b0, 1'b0, 9'h0F0, 1'b0, 1'b1}   // R6 low stop
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendChar(input logic [8:0] val, input logic nine,
                          input logic stopHi, input int bitClk);
    @(negedge clk);
    rxLine = 1'b0;
    idle(bitClk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxLine = val[i];
      idle(bitClk);
    end
    rxLine = stopHi;
    idle(bitClk);
    rxLine = 1'b1;
    idle(bitClk);
  endtask

  task automatic popOne();
    @(negedge clk);
    popStrobe = 1'b1;
    @(negedge clk);
    popStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    check("R1", "dataAvail", dataAvail, 0);
    check("R1", "rxData", rxData, 0);
    check("R1", "flags", {rxNinth, frameErr, overrunErr, breakWake}, 0);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      cfgNineBit = VECS[v].nine;
      cfgAddrDet = VECS[v].addr;
      sendChar(VECS[v].val, VECS[v].nine, VECS[v].stopHi, 16);
      check("R2/R3/R8 vector", "dataAvail", dataAvail, VECS[v].keep);
      if (VECS[v].keep) begin
        check("R2/R3 vector", "rxData", rxData, VECS[v].val[7:0]);
        check("R3 vector", "rxNinth", rxNinth, VECS[v].nine & VECS[v].val[8]);
        check("R6 vector", "frameErr", frameErr, !VECS[v].stopHi);
        popOne();
      end
      check("R5 vector", "empty after pop", dataAvail, 0);
    end
    cfgNineBit = 1'b0;
    cfgAddrDet = 1'b0;

    // R4 glitch shorter than half a bit
    @(negedge clk);
    rxLine = 1'b0;
    idle(5);
    rxLine = 1'b1;
    idle(60);
    check("R4", "glitch stored nothing", dataAvail, 0);
    sendChar(9'h03C, 1'b0, 1'b1, 16);
    check("R4", "next char rxData", rxData, 8'h3C);
    popOne();
    check("R4", "single char only", dataAvail, 0);

    // R5 ordering and head hold
    sendChar(9'h011, 1'b0, 1'b1, 16);
    sendChar(9'h022, 1'b0, 1'b1, 16);
    check("R5", "head is first", rxData, 8'h11);
    popOne();
    check("R5", "second after pop", rxData, 8'h22);
    popOne();
    check("R5", "empty", dataAvail, 0);

    // R6 error travels with its character
    sendChar(9'h044, 1'b0, 1'b0, 16);
    sendChar(9'h055, 1'b0, 1'b1, 16);
    check("R6", "head data", rxData, 8'h44);
    check("R6", "head ferr", frameErr, 1);
    popOne();
    check("R6", "second data", rxData, 8'h55);
    check("R6", "second ferr", frameErr, 0);
    popOne();

    // R7 overrun
    sendChar(9'h0A1, 1'b0, 1'b1, 16);
    sendChar(9'h0B2, 1'b0, 1'b1, 16);
    check("R7", "no overrun at two", overrunErr, 0);
    sendChar(9'h0C3, 1'b0, 1'b1, 16);
    check("R7", "overrun set", overrunErr, 1);
    check("R7", "head kept", rxData, 8'hA1);
    popOne();
    check("R7", "second kept", rxData, 8'hB2);
    popOne();
    check("R7", "third dropped", dataAvail, 0);
    sendChar(9'h0D4, 1'b0, 1'b1, 16);
    check("R7", "blocked while overrun", dataAvail, 0);
    check("R7", "still sticky", overrunErr, 1);
    @(negedge clk);
    clearRx = 1'b1;
    @(negedge clk);
    clearRx = 1'b0;
    check("R7", "cleared", overrunErr, 0);
    sendChar(9'h0E5, 1'b0, 1'b1, 16);
    check("R7", "accepts after clear", rxData, 8'hE5);
    popOne();

    // R9 break: line low for 13 bit periods
    wakeCnt = 0;
    @(negedge clk);
    rxLine = 1'b0;
    idle(13 * 16);
    rxLine = 1'b1;
    idle(32);
    check("R9", "wake pulse count", wakeCnt, 1);
    check("R9", "break stored", dataAvail, 1);
    check("R9", "break data", rxData, 0);
    check("R9", "break ferr", frameErr, 1);
    popOne();
    check("R9", "only one char from break", dataAvail, 0);
    sendChar(9'h05A, 1'b0, 1'b1, 16);
    check("R9", "recovers data", rxData, 8'h5A);
    check("R9", "recovers ferr", frameErr, 0);
    check("R9", "no extra wake", wakeCnt, 1);
    popOne();

    // R10 tick gating
    tickDiv = 3;
    sendChar(9'h096, 1'b0, 1'b1, 48);
    check("R10", "slow tick data", rxData, 8'h96);
    popOne();
    tickDiv = 1;
    tickOn = 1'b0;
    sendChar(9'h069, 1'b0, 1'b1, 16);
    check("R10", "no tick no receive", dataAvail, 0);
    tickOn = 1'b1;
    idle(20);
    check("R10", "still empty", dataAvail, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule